// File: doc/BRIEF.md
# Two-Delay Pipelined LMS Adaptive FIR Filter

This block is an adaptive FIR filter of parameterised length whose coefficients are trained by the least-mean-square rule. Each accepted sample `x_in` arrives with its desired response `d_in` under an `in_valid` strobe. The block forms the filter output from the current coefficients and the newest `NTAPS` input samples. It then takes the difference from the desired response as the error, and uses that error to nudge every coefficient. The step size is a power-of-two fraction and is realised as a fixed arithmetic shift.

The work is split over three register stages. The first stage holds the products, already summed in pairs, which is the first level of the adder tree. The second stage holds the full-precision output and the error. The third stage is the coefficient registers, which take their increments. As a result, each update uses the error of the sample two positions back, together with the input vector of that same sample. The tapped delay line is one position longer than the filter, so the old vector is read straight from it and is never stored twice.

The pipeline advances only on cycles with `in_valid` high. Gaps in the input stream therefore do not change the numerical result. A three-state fill controller tracks how far the pipeline has been loaded since reset:
- FILL_EMPTY: nothing has been accepted yet.
- FILL_HALF: one sample is held in stage one.
- RUN: an error is held in stage two, so updates are enabled.

The controller moves FILL_EMPTY to FILL_HALF to RUN, one step per accepted sample, and stays in RUN until reset. Samples are fixed point with `XW-1` fraction bits.

Top module: `lms2d_filter`

## Requirements
- R1: While reset is high and in the cycle after it falls, `out_valid`, `y_out`, `err_out` and every coefficient on `wt_out` are zero. All delay-line history is zero, so samples before reset count as 0.
- R2: For accepted sample n, `y_out` equals the exact signed sum over k of w_k(n)·x(n−k), where w_k(n) are the coefficients in force when sample n is accepted. This value is presented from the clock edge that accepts sample n+1.
- R3: `err_out` for sample n equals floor(((d(n)·2^(XW−1)) − y(n)) / 2^(XW−1)), limited to the XW-bit signed range. It is presented together with y(n).
- R4: The coefficients are packed with coefficient k at bits [k·XW +: XW] of `wt_out`. On each edge that accepts sample m in state RUN, w_k becomes w_k + floor(e(m−2)·x(m−2−k) / 2^(XW−1+MU_SHIFT)).
- R5: The first two accepted samples after reset leave all coefficients at zero. Coefficients change only on edges where `in_valid` is high and the fill controller is in RUN.
- R6: On a cycle with `in_valid` low, `y_out`, `err_out` and `wt_out` hold their values and `out_valid` is low after that edge.
- R7: `out_valid` is high for exactly the one cycle after each accepting edge, except the first accepting edge after reset.
- R8: A coefficient update whose result lies outside the XW-bit signed range is clamped to −2^(XW−1) or 2^(XW−1)−1.
- R9: An error whose scaled value exceeds the XW-bit signed range is clamped to the nearest limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `x_in` and `d_in` on this edge and advance the pipeline |
| x_in | input | XW | Input sample, signed, XW−1 fraction bits |
| d_in | input | XW | Desired response, signed, XW−1 fraction bits |
| out_valid | output | 1 | One-cycle pulse: a new `y_out`/`err_out` pair is present |
| y_out | output | 2·XW+clog2(NTAPS) | Full-precision filter output, 2·(XW−1) fraction bits |
| err_out | output | XW | Clamped error, XW−1 fraction bits |
| wt_out | output | NTAPS·XW | Packed signed coefficients, coefficient k at bits [k·XW +: XW] |

## Verification
A coefficient updated with the wrong error, the wrong vector, or on a wrong edge shows up on `wt_out` right after the edge where it happens. The next sample's `y_out`, one accepting edge later, then also deviates. A wrong fill state shows either as a premature coefficient change on the second accepted sample after reset, or as a missing `out_valid` pulse. A delay-line slip, or a clamp that wraps instead of limiting, shows in `y_out` or `err_out` within two accepted samples. Comparing every port on every cycle against a behavioural two-delay recursion therefore localises most faults to the edge that caused them.

// File: rtl/lms2d_pkg.sv
package lms2d_pkg;

    // Pipeline fill state after reset
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_HALF  = 2'd1,
        RUN        = 2'd2
    } fill_e;

endpackage

// File: rtl/lms2d_tap_line.sv
module lms2d_tap_line #(
    parameter int NTAPS = 8,
    parameter int XW    = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [XW-1:0] x_in,
    output logic signed [XW-1:0] dl_q [NTAPS+1]
);
    localparam int DEPTH = NTAPS + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) dl_q[i] <= '0;
        end else if (en) begin
            dl_q[0] <= x_in;
            for (int i = 1; i < DEPTH; i++) dl_q[i] <= dl_q[i-1];
        end
    end

    // R2: an accepted sample enters the newest history slot
    assert_tap_capture_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> dl_q[0] == $past(x_in));

endmodule

// File: rtl/lms2d_stage1.sv
module lms2d_stage1 #(
    parameter int NTAPS = 8,
    parameter int XW    = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [XW-1:0]   d_in,
    input  logic signed [XW-1:0]   tv   [NTAPS],
    input  logic signed [XW-1:0]   w    [NTAPS],
    output logic signed [2*XW:0]   pair_q [(NTAPS+1)/2],
    output logic signed [XW-1:0]   d_q
);
    localparam int PW    = 2 * XW;
    localparam int PSW   = PW + 1;
    localparam int NPAIR = (NTAPS + 1) / 2;

    logic signed [PW-1:0]  prod [NTAPS];
    logic signed [PSW-1:0] pair_d [NPAIR];

    genvar g;
    generate
        for (g = 0; g < NTAPS; g++) begin : g_mul
            assign prod[g] = PW'(w[g]) * PW'(tv[g]);
        end
        for (g = 0; g < NPAIR; g++) begin : g_pair
            if (2 * g + 1 < NTAPS) begin : g_two
                assign pair_d[g] = PSW'(prod[2*g]) + PSW'(prod[2*g+1]);
            end else begin : g_one
                assign pair_d[g] = PSW'(prod[2*g]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPAIR; i++) pair_q[i] <= '0;
            d_q <= '0;
        end else if (en) begin
            for (int i = 0; i < NPAIR; i++) pair_q[i] <= pair_d[i];
            d_q <= d_in;
        end
    end

endmodule

// File: rtl/lms2d_err_stage.sv
module lms2d_err_stage #(
    parameter int NTAPS = 8,
    parameter int XW    = 12
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load,
    input  logic signed [2*XW:0]                pair [(NTAPS+1)/2],
    input  logic signed [XW-1:0]                d,
    output logic signed [2*XW+$clog2(NTAPS)-1:0] y_q,
    output logic signed [XW-1:0]                e_q
);
    localparam int NPAIR = (NTAPS + 1) / 2;
    localparam int SW    = 2 * XW + $clog2(NTAPS);
    localparam int DFW   = SW + 1;
    localparam int FRAC  = XW - 1;
    localparam logic signed [DFW-1:0] EMAX = DFW'((1 <<< (XW - 1)) - 1);
    localparam logic signed [DFW-1:0] EMIN = DFW'(-(1 <<< (XW - 1)));

    logic signed [SW-1:0]  acc;
    logic signed [DFW-1:0] diff;
    logic signed [DFW-1:0] scaled;
    logic signed [XW-1:0]  e_d;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NPAIR; i++) acc = acc + SW'(pair[i]);
        diff   = (DFW'(d) <<< FRAC) - DFW'(acc);
        scaled = diff >>> FRAC;
        if (scaled > EMAX)      e_d = EMAX[XW-1:0];
        else if (scaled < EMIN) e_d = EMIN[XW-1:0];
        else                    e_d = scaled[XW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
            e_q <= '0;
        end else if (load) begin
            y_q <= acc;
            e_q <= e_d;
        end
    end

endmodule

// File: rtl/lms2d_weight_update.sv
module lms2d_weight_update #(
    parameter int NTAPS    = 8,
    parameter int XW       = 12,
    parameter int MU_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic signed [XW-1:0] err,
    input  logic signed [XW-1:0] old_vec [NTAPS],
    output logic signed [XW-1:0] w_q     [NTAPS]
);
    localparam int PW  = 2 * XW;
    localparam int SH  = XW - 1 + MU_SHIFT;
    localparam logic signed [PW:0] WMAX = (PW+1)'((1 <<< (XW - 1)) - 1);
    localparam logic signed [PW:0] WMIN = (PW+1)'(-(1 <<< (XW - 1)));

    logic signed [PW-1:0] prod [NTAPS];
    logic signed [PW:0]   sum  [NTAPS];
    logic signed [XW-1:0] w_d  [NTAPS];

    always_comb begin
        for (int k = 0; k < NTAPS; k++) begin
            prod[k] = PW'(err) * PW'(old_vec[k]);
            sum[k]  = (PW+1)'(w_q[k]) + (PW+1)'(prod[k] >>> SH);
            if (sum[k] > WMAX)      w_d[k] = WMAX[XW-1:0];
            else if (sum[k] < WMIN) w_d[k] = WMIN[XW-1:0];
            else                    w_d[k] = sum[k][XW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAPS; k++) w_q[k] <= '0;
        end else if (upd) begin
            for (int k = 0; k < NTAPS; k++) w_q[k] <= w_d[k];
        end
    end

endmodule

// File: rtl/lms2d_filter.sv
module lms2d_filter #(
    parameter int NTAPS    = 8,
    parameter int XW       = 12,
    parameter int MU_SHIFT = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic signed [XW-1:0]                 x_in,
    input  logic signed [XW-1:0]                 d_in,
    output logic                                 out_valid,
    output logic signed [2*XW+$clog2(NTAPS)-1:0] y_out,
    output logic signed [XW-1:0]                 err_out,
    output logic [NTAPS*XW-1:0]                  wt_out
);
    import lms2d_pkg::*;

    localparam int NPAIR = (NTAPS + 1) / 2;

    fill_e state_q, state_d;
    logic  load_err, upd_w;

    logic signed [XW-1:0] dl_q    [NTAPS+1];
    logic signed [XW-1:0] tap_vec [NTAPS];
    logic signed [XW-1:0] old_vec [NTAPS];
    logic signed [XW-1:0] w_q     [NTAPS];
    logic signed [2*XW:0] pair_q  [NPAIR];
    logic signed [XW-1:0] d_q;

    // Fill controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: if (in_valid) state_d = FILL_HALF;
            FILL_HALF:  if (in_valid) state_d = RUN;
            RUN:        state_d = RUN;
            default:    state_d = FILL_EMPTY;
        endcase
    end

    // Fill controller: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FILL_EMPTY;
        else     state_q <= state_d;
    end

    assign load_err = in_valid && (state_q != FILL_EMPTY);
    assign upd_w    = in_valid && (state_q == RUN);

    // Output strobe
    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= load_err;
    end

    genvar g;
    generate
        for (g = 0; g < NTAPS; g++) begin : g_vec
            if (g == 0) begin : g_head
                assign tap_vec[g] = x_in;
            end else begin : g_body
                assign tap_vec[g] = dl_q[g-1];
            end
            assign old_vec[g]            = dl_q[g+1];
            assign wt_out[g*XW +: XW]    = w_q[g];
        end
    endgenerate

    lms2d_tap_line #(.NTAPS(NTAPS), .XW(XW)) u_taps (
        .clk(clk), .rst(rst), .en(in_valid), .x_in(x_in), .dl_q(dl_q)
    );

    lms2d_stage1 #(.NTAPS(NTAPS), .XW(XW)) u_stage1 (
        .clk(clk), .rst(rst), .en(in_valid), .d_in(d_in),
        .tv(tap_vec), .w(w_q), .pair_q(pair_q), .d_q(d_q)
    );

    lms2d_err_stage #(.NTAPS(NTAPS), .XW(XW)) u_err (
        .clk(clk), .rst(rst), .load(load_err), .pair(pair_q), .d(d_q),
        .y_q(y_out), .e_q(err_out)
    );

    lms2d_weight_update #(.NTAPS(NTAPS), .XW(XW), .MU_SHIFT(MU_SHIFT)) u_upd (
        .clk(clk), .rst(rst), .upd(upd_w), .err(err_out),
        .old_vec(old_vec), .w_q(w_q)
    );

    // R7: a result strobe always follows an accepted sample
    assert_outvalid_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5: coefficients frozen unless accepting in RUN
    assert_wt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && state_q == RUN) |=> $stable(wt_out));

    // R5: once filled the controller stays in RUN
    assert_run_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == RUN) |=> (state_q == RUN));

    // R6: an idle cycle leaves the results in place
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(y_out) && $stable(err_out) && !out_valid));

endmodule

// File: tb/lms2d_filter_bench.sv
`timescale 1ns/1ps
module lms2d_filter_bench;
    localparam int NTAPS    = 8;
    localparam int XW       = 12;
    localparam int MU_SHIFT = 2;
    localparam int FRAC     = XW - 1;
    localparam int SW       = 2 * XW + $clog2(NTAPS);
    localparam longint LIM_HI = (1 <<< (XW - 1)) - 1;
    localparam longint LIM_LO = -(1 <<< (XW - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [XW-1:0] x_in = '0;
    logic signed [XW-1:0] d_in = '0;
    logic out_valid;
    logic signed [SW-1:0] y_out;
    logic signed [XW-1:0] err_out;
    logic [NTAPS*XW-1:0] wt_out;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lms2d_filter #(.NTAPS(NTAPS), .XW(XW), .MU_SHIFT(MU_SHIFT)) u_lms2d_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
        .out_valid(out_valid), .y_out(y_out), .err_out(err_out), .wt_out(wt_out)
    );

    // Behavioural model state
    longint m_hist [NTAPS+1];
    longint m_w    [NTAPS];
    longint m_ypend, m_dpend, m_eq, m_y, m_e;
    bit     m_h1, m_h2, m_ov;

    // Previous sampled DUT values for the idle-hold checks
    longint p_y, p_e;
    logic [NTAPS*XW-1:0] p_w;

    function automatic longint clampv(longint v);
        if (v > LIM_HI) return LIM_HI;
        if (v < LIM_LO) return LIM_LO;
        return v;
    endfunction

    function automatic longint dut_w(int k);
        logic signed [XW-1:0] t;
        t = wt_out[k*XW +: XW];
        return longint'(t);
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i <= NTAPS; i++) m_hist[i] = 0;
        for (int i = 0; i < NTAPS; i++) m_w[i] = 0;
        m_ypend = 0; m_dpend = 0; m_eq = 0; m_y = 0; m_e = 0;
        m_h1 = 0; m_h2 = 0; m_ov = 0;
    endtask

    task automatic model_step(bit v, longint xv, longint dv);
        longint s;
        m_ov = 0;
        if (v) begin
            s = 0;
            for (int k = 0; k < NTAPS; k++)
                s += m_w[k] * ((k == 0) ? xv : m_hist[k-1]);
            if (m_h2)
                for (int k = 0; k < NTAPS; k++)
                    m_w[k] = clampv(m_w[k] + ((m_eq * m_hist[k+1]) >>> (FRAC + MU_SHIFT)));
            if (m_h1) begin
                m_y  = m_ypend;
                m_e  = clampv(((m_dpend <<< FRAC) - m_ypend) >>> FRAC);
                m_eq = m_e;
                m_ov = 1;
            end
            m_h2 = m_h1;
            m_ypend = s;
            m_dpend = dv;
            m_h1 = 1;
            for (int k = NTAPS; k >= 1; k--) m_hist[k] = m_hist[k-1];
            m_hist[0] = xv;
        end
    endtask

    task automatic compare_all(bit v);
        chk("R7 out_valid", longint'(out_valid), longint'(m_ov));
        chk("R2 y_out", longint'(y_out), m_y);
        chk("R3 err_out", longint'(err_out), m_e);
        for (int k = 0; k < NTAPS; k++) chk("R4 weight", dut_w(k), m_w[k]);
        if (!v) begin
            chk("R6 idle y hold", longint'(y_out), p_y);
            chk("R6 idle err hold", longint'(err_out), p_e);
            chk("R6 idle weight hold", longint'(wt_out == p_w), 1);
            chk("R6 idle out_valid low", longint'(out_valid), 0);
        end
        p_y = longint'(y_out);
        p_e = longint'(err_out);
        p_w = wt_out;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic cyc(bit v, longint xv, longint dv);
        in_valid = v;
        x_in = XW'(xv);
        d_in = XW'(dv);
        @(posedge clk);
        model_step(v, xv, dv);
        @(negedge clk);
        compare_all(v);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset out_valid", longint'(out_valid), 0);
        chk("R1 reset y_out", longint'(y_out), 0);
        chk("R1 reset err_out", longint'(err_out), 0);
        chk("R1 reset weights", longint'(wt_out == '0), 1);
        p_y = 0; p_e = 0; p_w = '0;
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL R2 watchdog: done=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin : main
        longint h [NTAPS];
        longint sys_hist [NTAPS];
        longint xv, dv, acc;
        bit v;
        h = '{300, -200, 150, 0, 80, -40, 20, 10};
        for (int i = 0; i < NTAPS; i++) sys_hist[i] = 0;
        model_reset();
        @(negedge clk);
        do_reset();

        // Identification with random gaps in the stream
        for (int n = 0; n < 300; n++) begin
            v  = ($urandom % 4) != 0;
            xv = longint'($urandom % 2048) - 1024;
            dv = 0;
            if (v) begin
                for (int k = NTAPS - 1; k >= 1; k--) sys_hist[k] = sys_hist[k-1];
                sys_hist[0] = xv;
                acc = 0;
                for (int k = 0; k < NTAPS; k++) acc += h[k] * sys_hist[k];
                dv = clampv(acc >>> FRAC);
            end
            cyc(v, xv, dv);
        end

        // Fill behaviour and coefficient clamping from a fresh reset
        do_reset();
        cyc(1, 64, -2048);
        cyc(1, 64, -2048);
        chk("R5 weights zero after two samples", longint'(wt_out == '0), 1);
        cyc(1, 64, -2048);
        chk("R5 first update w0", dut_w(0), -16);
        chk("R5 first update w1", dut_w(1), 0);
        for (int n = 0; n < 400; n++) cyc(1, 64, -2048);
        for (int k = 0; k < NTAPS; k++) chk("R8 weight clamped low", dut_w(k), LIM_LO);

        // Error clamping: coefficients at the low limit, desired at the top
        cyc(1, 64, 2047);
        cyc(1, 64, 2047);
        chk("R2 y with clamped weights", longint'(y_out), -1048576);
        chk("R9 err clamped high", longint'(err_out), LIM_HI);
        chk("R7 strobe present", longint'(out_valid), 1);
        cyc(0, 0, 0);
        chk("R9 err held on idle", longint'(err_out), LIM_HI);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule